// File: doc/BRIEF.md
# Posted Column Command Scheduler

This block sits between a memory command front end and the bank logic of a DRAM controller. A read or write column command may be presented as early as the clock after its bank was opened, before the row-to-column delay (tRCD) has run out. The block holds each accepted command for a programmed additive latency (AL, 0 to 4 clocks) and then hands it to the bank as an internal column command. The AL must be large enough that the internal issue falls no earlier than tRCD clocks after the activate.

Each bank has an age counter that starts on its activate. A new column command is checked against three rules: its bank must be open, the age plus AL must reach tRCD, and the command must come at least tCCD clocks after the last accepted one. A command that breaks any rule raises a one-clock error pulse and is discarded. Accepted commands enter a short in-order queue whose entries carry a countdown. A small controller with two states, `ST_IDLE` (nothing pending) and `ST_BUSY` (at least one pending), governs when the AL setting may change. It moves `ST_IDLE -> ST_BUSY` when a command is accepted. It moves `ST_BUSY -> ST_IDLE` when the last pending entry issues and no new command is accepted in the same clock. All other cases hold the state.

Top module: `posted_col_sched`

## Requirements
- R1: After reset no bank is open, AL is 0, `iss_valid` is low and `err` is low.
- R2: A column command to a bank that has no earlier activate, including an activate presented in the same clock, raises `err` in the next clock and never appears on the issue port.
- R3: An accepted command appears on the issue port with its own `iss_write`, `iss_bank` and `iss_col` for exactly one clock, AL+1 clocks after the clock in which it was presented.
- R4: A command presented k clocks after its bank's activate is accepted only when k + AL >= `trcd`, with k saturating at 15. Otherwise `err` pulses in the next clock and the command is dropped. A command presented on the clock right after an activate is therefore accepted when 1 + AL >= `trcd`.
- R5: A command presented fewer than `tccd` clocks after the last accepted command raises `err` and is dropped. A rejected command does not restart the spacing count.
- R6: An AL load with a value from 0 to 4 applies to commands presented in later clocks. A value above 4 raises `err` and the previous AL is kept.
- R7: An AL load while any command is pending (`ST_BUSY`) raises `err` and the previous AL is kept.
- R8: Commands leave in the order they were accepted. With `tccd` of 1 and AL of 4, a command in every clock is accepted, which leaves up to AL+1 pending at once without loss.
- R9: The controller is in `ST_IDLE` exactly when no command is pending.
- R10: A new activate to an already open bank restarts that bank's tRCD age.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| act_valid | input | 1 | Activate event this clock |
| act_bank | input | 3 | Bank being activated |
| cmd_valid | input | 1 | Column command presented this clock |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_bank | input | 3 | Target bank of the column command |
| cmd_col | input | 10 | Column address |
| al_load | input | 1 | Request to load a new additive latency |
| al_value | input | 3 | Requested additive latency |
| trcd | input | 4 | Row-to-column delay in clocks |
| tccd | input | 4 | Minimum column command spacing in clocks |
| iss_valid | output | 1 | Internal column command issued this clock |
| iss_write | output | 1 | Write flag of the issued command |
| iss_bank | output | 3 | Bank of the issued command |
| iss_col | output | 10 | Column of the issued command |
| err | output | 1 | One-clock pulse: illegal request in the previous clock |

## Verification
The error pulse is due one clock after the offending request, and an accepted command is due on the issue port AL+1 clocks after the clock in which it was presented. The bench drives inputs on the falling edge and compares every output on each falling edge against a behavioural model. The model keeps pending commands as due-clock stamps in a queue and logs an error one clock after it decides a request is illegal. A changed AL takes effect for the model only after the command of the same clock has been stamped. Because of this, wrong AL capture, age or spacing arithmetic, or queue order shows up on the exact clock where the result is due.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    // Controller state: nothing pending, or at least one posted command waiting.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } sched_state_e;

endpackage

// File: rtl/pcs_bank_timer.sv
module pcs_bank_timer #(
    parameter int NUM_BANKS = 8,
    parameter int AGE_W     = 4,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              act_valid,
    input  logic [BA_W-1:0]                   act_bank,
    output logic [NUM_BANKS-1:0]              bank_open,
    output logic [NUM_BANKS-1:0][AGE_W-1:0]   bank_age
);

    localparam logic [AGE_W-1:0] AGE_MAX = '1;

    // One open flag and saturating age counter per bank.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank_open[b] <= 1'b0;
                bank_age[b]  <= '0;
            end else if (act_valid && act_bank == BA_W'(b)) begin
                bank_open[b] <= 1'b1;
                bank_age[b]  <= AGE_W'(1);
            end else if (bank_open[b] && bank_age[b] != AGE_MAX) begin
                bank_age[b]  <= bank_age[b] + AGE_W'(1);
            end
        end
    end

endmodule

// File: rtl/pcs_post_queue.sv
module pcs_post_queue #(
    parameter int DEPTH = 5,
    parameter int DLY_W = 3,
    parameter int BA_W  = 3,
    parameter int COL_W = 10,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             push_write,
    input  logic [BA_W-1:0]  push_bank,
    input  logic [COL_W-1:0] push_col,
    input  logic [DLY_W-1:0] push_delay,
    output logic             head_ready,
    output logic             head_write,
    output logic [BA_W-1:0]  head_bank,
    output logic [COL_W-1:0] head_col,
    output logic [CNT_W-1:0] count
);

    logic             wr_q   [DEPTH];
    logic [BA_W-1:0]  bank_q [DEPTH];
    logic [COL_W-1:0] col_q  [DEPTH];
    logic [DLY_W-1:0] dly_q  [DEPTH];
    logic [CNT_W-1:0] cnt_q;

    logic             wr_d   [DEPTH];
    logic [BA_W-1:0]  bank_d [DEPTH];
    logic [COL_W-1:0] col_d  [DEPTH];
    logic [DLY_W-1:0] dly_d  [DEPTH];
    logic [CNT_W-1:0] cnt_d;

    assign head_ready = (cnt_q != '0) && (dly_q[0] == '0);
    assign head_write = wr_q[0];
    assign head_bank  = bank_q[0];
    assign head_col   = col_q[0];
    assign count      = cnt_q;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            if (head_ready) begin
                if (i == DEPTH - 1) begin
                    wr_d[i]   = 1'b0;
                    bank_d[i] = '0;
                    col_d[i]  = '0;
                    dly_d[i]  = '0;
                end else begin
                    wr_d[i]   = wr_q[i+1];
                    bank_d[i] = bank_q[i+1];
                    col_d[i]  = col_q[i+1];
                    dly_d[i]  = dly_q[i+1];
                end
            end else begin
                wr_d[i]   = wr_q[i];
                bank_d[i] = bank_q[i];
                col_d[i]  = col_q[i];
                dly_d[i]  = dly_q[i];
            end
            if (dly_d[i] != '0) begin
                dly_d[i] = dly_d[i] - DLY_W'(1);
            end
        end
        cnt_d = head_ready ? cnt_q - CNT_W'(1) : cnt_q;
        if (push) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (cnt_d == CNT_W'(i)) begin
                    wr_d[i]   = push_write;
                    bank_d[i] = push_bank;
                    col_d[i]  = push_col;
                    dly_d[i]  = push_delay;
                end
            end
            cnt_d = cnt_d + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                wr_q[i]   <= 1'b0;
                bank_q[i] <= '0;
                col_q[i]  <= '0;
                dly_q[i]  <= '0;
            end
        end else begin
            cnt_q <= cnt_d;
            for (int i = 0; i < DEPTH; i++) begin
                wr_q[i]   <= wr_d[i];
                bank_q[i] <= bank_d[i];
                col_q[i]  <= col_d[i];
                dly_q[i]  <= dly_d[i];
            end
        end
    end

endmodule

// File: rtl/posted_col_sched.sv
module posted_col_sched
    import pcs_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int COL_W     = 10,
    parameter int AL_MAX    = 4,
    parameter int T_W       = 4,
    localparam int BA_W     = $clog2(NUM_BANKS),
    localparam int AL_W     = $clog2(AL_MAX + 1),
    localparam int DEPTH    = AL_MAX + 1,
    localparam int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_valid,
    input  logic [BA_W-1:0]  act_bank,
    input  logic             cmd_valid,
    input  logic             cmd_write,
    input  logic [BA_W-1:0]  cmd_bank,
    input  logic [COL_W-1:0] cmd_col,
    input  logic             al_load,
    input  logic [AL_W-1:0]  al_value,
    input  logic [T_W-1:0]   trcd,
    input  logic [T_W-1:0]   tccd,
    output logic             iss_valid,
    output logic             iss_write,
    output logic [BA_W-1:0]  iss_bank,
    output logic [COL_W-1:0] iss_col,
    output logic             err
);

    localparam logic [AL_W-1:0] AL_LIMIT = AL_W'(AL_MAX);
    localparam logic [T_W-1:0]  GAP_MAX  = '1;

    sched_state_e                      state_q, state_d;
    logic [AL_W-1:0]                   al_q;
    logic [T_W-1:0]                    since_q;
    logic                              err_q;

    logic [NUM_BANKS-1:0]              bank_open;
    logic [NUM_BANKS-1:0][T_W-1:0]     bank_age;
    logic [CNT_W-1:0]                  q_count;
    logic                              head_ready;

    logic                              rcd_ok, ccd_ok, cmd_ok, cmd_bad, al_bad;

    pcs_bank_timer #(
        .NUM_BANKS (NUM_BANKS),
        .AGE_W     (T_W)
    ) u_banks (
        .clk       (clk),
        .rst_n     (rst_n),
        .act_valid (act_valid),
        .act_bank  (act_bank),
        .bank_open (bank_open),
        .bank_age  (bank_age)
    );

    pcs_post_queue #(
        .DEPTH (DEPTH),
        .DLY_W (AL_W),
        .BA_W  (BA_W),
        .COL_W (COL_W)
    ) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (cmd_ok),
        .push_write (cmd_write),
        .push_bank  (cmd_bank),
        .push_col   (cmd_col),
        .push_delay (al_q),
        .head_ready (head_ready),
        .head_write (iss_write),
        .head_bank  (iss_bank),
        .head_col   (iss_col),
        .count      (q_count)
    );

    // Legality of the column command presented this clock.
    assign rcd_ok  = ({1'b0, bank_age[cmd_bank]} + (T_W+1)'(al_q)) >= {1'b0, trcd};
    assign ccd_ok  = since_q >= tccd;
    assign cmd_ok  = cmd_valid && bank_open[cmd_bank] && rcd_ok && ccd_ok;
    assign cmd_bad = cmd_valid && !cmd_ok;
    assign al_bad  = al_load && ((al_value > AL_LIMIT) || (state_q != ST_IDLE));

    assign iss_valid = head_ready;
    assign err       = err_q;

    // Next state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cmd_ok) state_d = ST_BUSY;
            ST_BUSY: if (q_count == CNT_W'(1) && head_ready && !cmd_ok) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Registered results: AL setting, spacing count, error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            al_q    <= '0;
            since_q <= GAP_MAX;
            err_q   <= 1'b0;
        end else begin
            err_q <= cmd_bad || al_bad;
            if (al_load && !al_bad) al_q <= al_value;
            if (cmd_ok)                   since_q <= T_W'(1);
            else if (since_q != GAP_MAX)  since_q <= since_q + T_W'(1);
        end
    end

endmodule

// File: rtl/posted_col_sched_chk.sv
module posted_col_sched_chk
    import pcs_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int AL_MAX    = 4,
    localparam int BA_W     = $clog2(NUM_BANKS),
    localparam int AL_W     = $clog2(AL_MAX + 1),
    localparam int DEPTH    = AL_MAX + 1,
    localparam int CNT_W    = $clog2(DEPTH + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cmd_valid,
    input logic [BA_W-1:0]      cmd_bank,
    input logic                 al_load,
    input logic [AL_W-1:0]      al_value,
    input logic [AL_W-1:0]      al_q,
    input logic [NUM_BANKS-1:0] bank_open,
    input logic [CNT_W-1:0]     q_count,
    input sched_state_e         state_q,
    input logic                 err
);

    // R9
    idle_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) == (q_count == '0));

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= CNT_W'(DEPTH));

    // R2
    closed_bank_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !bank_open[cmd_bank]) |=> err);

    // R6
    al_range_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (al_load && al_value > AL_W'(AL_MAX)) |=> (err && $stable(al_q)));

    // R7
    al_busy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (al_load && state_q == ST_BUSY) |=> (err && $stable(al_q)));

endmodule

bind posted_col_sched posted_col_sched_chk #(
    .NUM_BANKS (NUM_BANKS),
    .AL_MAX    (AL_MAX)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_bank  (cmd_bank),
    .al_load   (al_load),
    .al_value  (al_value),
    .al_q      (al_q),
    .bank_open (bank_open),
    .q_count   (q_count),
    .state_q   (state_q),
    .err       (err)
);

// File: tb/posted_col_sched_bench.sv
module posted_col_sched_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       act_valid;
    logic [2:0] act_bank;
    logic       cmd_valid;
    logic       cmd_write;
    logic [2:0] cmd_bank;
    logic [9:0] cmd_col;
    logic       al_load;
    logic [2:0] al_value;
    logic [3:0] trcd;
    logic [3:0] tccd;
    logic       iss_valid;
    logic       iss_write;
    logic [2:0] iss_bank;
    logic [9:0] iss_col;
    logic       err;

    always #10 clk = ~clk;  // 50 MHz

    posted_col_sched u_posted_col_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .act_valid (act_valid),
        .act_bank  (act_bank),
        .cmd_valid (cmd_valid),
        .cmd_write (cmd_write),
        .cmd_bank  (cmd_bank),
        .cmd_col   (cmd_col),
        .al_load   (al_load),
        .al_value  (al_value),
        .trcd      (trcd),
        .tccd      (tccd),
        .iss_valid (iss_valid),
        .iss_write (iss_write),
        .iss_bank  (iss_bank),
        .iss_col   (iss_col),
        .err       (err)
    );

    // Behavioural reference model.
    typedef struct { int due; bit wr; int bank; int col; } pend_t;
    pend_t pend[$];
    bit    opened [8];
    int    act_at [8];
    int    last_acc = -100;
    int    al_m     = 0;
    bit    err_exp  = 1'b0;
    int    cyc      = 0;
    int    checks   = 0;
    int    errors   = 0;
    int    wd       = 0;
    bit    done     = 1'b0;
    string cur_req  = "R1";

    task automatic check(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s cycle %0d %s actual=%0d expected=%0d", cur_req, cyc, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        act_valid = 1'b0; act_bank = '0;
        cmd_valid = 1'b0; cmd_write = 1'b0; cmd_bank = '0; cmd_col = '0;
        al_load = 1'b0; al_value = '0;
    endtask

    // Called at a falling edge with this clock's inputs already driven.
    task automatic step();
        bit exp_iv;
        bit busy;
        bit nerr;
        int age, since, b;
        pend_t e;
        exp_iv = (pend.size() > 0) && (pend[0].due == cyc);
        check("err", int'(err), int'(err_exp));
        check("iss_valid", int'(iss_valid), int'(exp_iv));
        if (exp_iv) begin
            check("iss_write", int'(iss_write), int'(pend[0].wr));
            check("iss_bank", int'(iss_bank), pend[0].bank);
            check("iss_col", int'(iss_col), pend[0].col);
        end
        busy = pend.size() > 0;
        if (exp_iv) void'(pend.pop_front());
        nerr = 1'b0;
        if (cmd_valid) begin
            b     = int'(cmd_bank);
            age   = opened[b] ? ((cyc - act_at[b]) > 15 ? 15 : (cyc - act_at[b])) : 0;
            since = (cyc - last_acc) > 15 ? 15 : (cyc - last_acc);
            if (opened[b] && age + al_m >= int'(trcd) && since >= int'(tccd)) begin
                e.due = cyc + al_m + 1; e.wr = cmd_write; e.bank = b; e.col = int'(cmd_col);
                pend.push_back(e);
                last_acc = cyc;
            end else begin
                nerr = 1'b1;
            end
        end
        if (act_valid) begin
            opened[int'(act_bank)] = 1'b1;
            act_at[int'(act_bank)] = cyc;
        end
        if (al_load) begin
            if (int'(al_value) > 4 || busy) nerr = 1'b1;
            else al_m = int'(al_value);
        end
        err_exp = nerr;
        @(posedge clk);
        @(negedge clk);
        cyc++;
        idle_inputs();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic cmd(input bit w, input int b, input int col);
        cmd_valid = 1'b1; cmd_write = w; cmd_bank = 3'(b); cmd_col = 10'(col);
    endtask

    task automatic act(input int b);
        act_valid = 1'b1; act_bank = 3'(b);
    endtask

    task automatic load_al(input int v);
        al_load = 1'b1; al_value = 3'(v);
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 5000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin opened[i] = 1'b0; act_at[i] = 0; end
        idle_inputs();
        trcd  = 4'd3;
        tccd  = 4'd2;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        cur_req = "R1";
        idle(3);

        cur_req = "R2";
        cmd(0, 5, 'h005); step(); idle(1);
        act(1); cmd(1, 1, 'h011); step(); idle(2);

        cur_req = "R3";
        act(0); step(); idle(2);
        cmd(0, 0, 'h0a1); step(); idle(3);

        cur_req = "R4";
        act(3); step();
        cmd(1, 3, 'h033); step(); idle(3);

        cur_req = "R6";
        load_al(2); step(); idle(1);
        act(2); step();
        cmd(0, 2, 'h122); step(); idle(4);
        load_al(5); step(); idle(1);
        act(4); step();
        cmd(1, 4, 'h144); step(); idle(4);

        cur_req = "R7";
        cmd(1, 0, 'h200); step();
        load_al(0); step(); idle(4);

        cur_req = "R5";
        cmd(0, 0, 'h250); step();
        cmd(0, 1, 'h251); step();
        cmd(1, 2, 'h252); step(); idle(5);

        cur_req = "R8";
        tccd = 4'd1;
        load_al(4); step(); idle(1);
        for (int i = 0; i < 6; i++) begin
            cmd(i[0], i % 5, 'h300 + i); step();
        end
        idle(8);

        cur_req = "R10";
        load_al(0); step(); idle(1);
        act(0); step();
        cmd(0, 0, 'h3a0); step(); idle(1);
        cmd(1, 0, 'h3a1); step(); idle(3);

        cur_req = "R4";
        trcd = 4'd15;
        idle(16);
        cmd(0, 2, 'h3ff); step(); idle(3);
        trcd = 4'd3;

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule